// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Shared Polarity Field

This block is one capture/compare channel that sits beside a free-running timer counter. The counter value and an update-event strobe come in from outside. In compare (output) mode the channel checks the counter against a programmable threshold. It drives an output whose active level software selects, and it pulses a flag on an exact match. In capture (input) mode it watches an external signal for a selected edge and stores the counter value at that moment.

A single two-bit polarity field serves both directions. In compare mode it picks an active-high or active-low output. In capture mode it picks the rising edge, the falling edge or both edges as the capture event, and it decides whether the conditioned input handed downstream is inverted. A two-bit protection-level input locks the polarity field against writes. In compare mode the threshold can be double-buffered so that it takes effect only on an update event. Software reaches the channel through a small write port with three addresses. The configuration and the channel value are brought out for readback.

Top module: `tcc_channel`

## Requirements
- R1: While reset is held, `ctrl_rd`, `ch_value`, `cap_flag`, `ovr_flag`, `cmp_out` and `match_pulse` are all zero. Zero in `ctrl_rd` means compare mode, polarity code 00 and double-buffering off.
- R2: Write addresses are as follows. Address 0 is control: bit 0 is the mode (1 = capture, 0 = compare), bit 1 enables double-buffering and bits 3:2 hold the polarity code. Address 1 is the channel value. Address 2 is the status clear. Reads of control come back on `ctrl_rd` in the same bit positions.
- R3: In compare mode, `cmp_out` shows in the cycle after the counter is presented whether the counter is greater than or equal to the active threshold. It is uninverted for polarity code 00 and inverted for code 01. In capture mode `cmp_out` is low.
- R4: In compare mode, polarity codes 10 and 11 leave the output at the level sense last set by code 00 or 01.
- R5: In compare mode, `match_pulse` is high in the cycle after the counter equals the active threshold, and low otherwise.
- R6: With double-buffering off, a value write in compare mode updates the active threshold on the clock edge that takes the write.
- R7: With double-buffering on, a value write in compare mode goes only to a hidden buffer. `ch_value` keeps the old threshold until a cycle with `upd_evt` high copies the buffer in.
- R8: The input passes through two synchronizing flip-flops. In capture mode with code 00, a rising edge loads the counter value into `ch_value`, three clock edges after the input changes.
- R9: In capture mode with code 01, only falling edges capture, and `sig_cond` is the synchronized input inverted. For every other code `sig_cond` is uninverted.
- R10: In capture mode, code 11 captures on both edges and code 10 captures on none.
- R11: In capture mode, writes to the value address are ignored.
- R12: Each capture sets `cap_flag`. Writing 1 to bit 0 of the status address clears it, and writing 1 to bit 1 clears `ovr_flag`. A capture while `cap_flag` is already set also sets `ovr_flag`. A capture in the same cycle as a clear leaves `cap_flag` set.
- R13: While `prot_lvl` is 2'b10 or 2'b11, control writes leave the polarity code unchanged but still update the mode and double-buffer bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Current timer counter value |
| upd_evt | input | 1 | Update-event strobe, one cycle |
| prot_lvl | input | 2 | Protection level; top bit set locks the polarity code |
| sig_in | input | 1 | Asynchronous external capture input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| ctrl_rd | output | 4 | Control readback: {polarity, buffer enable, mode} |
| ch_value | output | CNT_W | Active threshold or last captured count |
| cap_flag | output | 1 | Capture-occurred flag |
| ovr_flag | output | 1 | Overcapture flag |
| cmp_out | output | 1 | Compare output after polarity |
| match_pulse | output | 1 | Counter-equals-threshold flag |
| sig_cond | output | 1 | Synchronized input after polarity |

## Verification
The bench builds the channel with an 8-bit counter, so the compare path can be swept over all 256 counter values. The sweep covers thresholds at zero, mid-range and full-scale under both output senses, which places the greater-or-equal boundary and the match point at each end of the range. In capture mode the bench walks every polarity code through rising and falling transitions, checking the captured count and the flag state. It separately drives the clear-versus-capture collision and the protection lock.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        POL_NORM = 2'b00,
        POL_INV  = 2'b01,
        POL_RSVD = 2'b10,
        POL_BOTH = 2'b11
    } pol_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_VAL  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/tcc_edge_det.sv
module tcc_edge_det
    import tcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_in,
    input  logic       in_mode,
    input  logic [1:0] pol,
    output logic       cap_evt,
    output logic       sig_cond
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } state_t;

    state_t st_d, st_q;
    logic   cur, prv, rise, fall;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], sig_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.chain[SYNC_STAGES-1];
    assign prv  = st_q.chain[SYNC_STAGES];
    assign rise = cur & ~prv;
    assign fall = ~cur & prv;

    always_comb begin
        cap_evt = 1'b0;
        if (in_mode) begin
            unique case (pol)
                POL_NORM: cap_evt = rise;
                POL_INV:  cap_evt = fall;
                POL_BOTH: cap_evt = rise | fall;
                default:  cap_evt = 1'b0;
            endcase
        end
    end

    assign sig_cond = (pol == POL_INV) ? ~cur : cur;

    // R8: a rising capture coincides with the conditioned input going high
    p_rise_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && pol == POL_NORM && $stable(pol)) |-> (sig_cond && !$past(sig_cond)));

endmodule

// File: rtl/tcc_cmp_unit.sv
module tcc_cmp_unit
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] thr,
    input  logic             out_mode,
    input  logic [1:0]       pol,
    output logic             cmp_out,
    output logic             match_pulse
);

    typedef struct packed {
        logic ge;
        logic eq;
        logic inv;
        logic omode;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ge    = (cnt_val >= thr);
        st_d.eq    = out_mode && (cnt_val == thr);
        st_d.omode = out_mode;
        if (pol == POL_NORM)     st_d.inv = 1'b0;
        else if (pol == POL_INV) st_d.inv = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_out     = st_q.omode & (st_q.ge ^ st_q.inv);
    assign match_pulse = st_q.eq;

    // R5: an exact match always lies inside the greater-or-equal region
    p_match_ge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> st_q.ge);

    // R3: nothing is driven in capture mode
    p_idle_in_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.omode |-> !cmp_out && !match_pulse);

endmodule

// File: rtl/tcc_regs.sv
module tcc_regs
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       prot_lvl,
    input  logic             upd_evt,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cap_evt,
    output logic             in_mode,
    output logic [1:0]       pol,
    output logic [3:0]       ctrl_rd,
    output logic [CNT_W-1:0] active_val,
    output logic             cap_flag,
    output logic             ovr_flag
);

    typedef struct packed {
        logic             in_mode;
        logic             shd_en;
        logic [1:0]       pol;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] shadow;
        logic             cap;
        logic             ovr;
    } state_t;

    state_t st_d, st_q;
    logic   pol_locked;

    assign pol_locked = prot_lvl[1];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    st_d.in_mode = wr_data[0];
                    st_d.shd_en  = wr_data[1];
                    if (!pol_locked) st_d.pol = wr_data[3:2];
                end
                ADDR_VAL: begin
                    if (!st_q.in_mode) begin
                        if (st_q.shd_en) st_d.shadow = wr_data;
                        else             st_d.active = wr_data;
                    end
                end
                ADDR_STAT: begin
                    if (wr_data[0]) st_d.cap = 1'b0;
                    if (wr_data[1]) st_d.ovr = 1'b0;
                end
                default: ;
            endcase
        end
        if (!st_q.in_mode && st_q.shd_en && upd_evt) st_d.active = st_q.shadow;
        if (cap_evt) begin
            st_d.active = cnt_val;
            st_d.cap    = 1'b1;
            if (st_q.cap) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_mode    = st_q.in_mode;
    assign pol        = st_q.pol;
    assign ctrl_rd    = {st_q.pol, st_q.shd_en, st_q.in_mode};
    assign active_val = st_q.active;
    assign cap_flag   = st_q.cap;
    assign ovr_flag   = st_q.ovr;

    // R13: locked polarity survives control writes
    p_pol_lock_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && prot_lvl[1]) |=> (pol == $past(pol)));

    // R8: a capture loads the counter and raises the flag
    p_cap_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (active_val == $past(cnt_val)) && cap_flag);

    // R12: overcapture only arises on top of a pending capture
    p_ovr_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(cap_flag));

    // R11: value writes in capture mode do not disturb the register
    p_ro_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mode && !cap_evt && wr_en && wr_addr == ADDR_VAL) |=> $stable(active_val));

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             upd_evt,
    input  logic [1:0]       prot_lvl,
    input  logic             sig_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [3:0]       ctrl_rd,
    output logic [CNT_W-1:0] ch_value,
    output logic             cap_flag,
    output logic             ovr_flag,
    output logic             cmp_out,
    output logic             match_pulse,
    output logic             sig_cond
);

    logic       in_mode;
    logic [1:0] pol;
    logic       cap_evt;

    tcc_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .prot_lvl   (prot_lvl),
        .upd_evt    (upd_evt),
        .cnt_val    (cnt_val),
        .cap_evt    (cap_evt),
        .in_mode    (in_mode),
        .pol        (pol),
        .ctrl_rd    (ctrl_rd),
        .active_val (ch_value),
        .cap_flag   (cap_flag),
        .ovr_flag   (ovr_flag)
    );

    tcc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .in_mode  (in_mode),
        .pol      (pol),
        .cap_evt  (cap_evt),
        .sig_cond (sig_cond)
    );

    tcc_cmp_unit #(.CNT_W(CNT_W)) cmp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_val     (cnt_val),
        .thr         (ch_value),
        .out_mode    (!in_mode),
        .pol         (pol),
        .cmp_out     (cmp_out),
        .match_pulse (match_pulse)
    );

endmodule

// File: tb/tcc_channel_tb_top.sv
`timescale 1ns/1ps
module tcc_channel_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         upd_evt = 1'b0;
    logic [1:0]   prot_lvl = 2'b00;
    logic         sig_in = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [3:0]   ctrl_rd;
    logic [W-1:0] ch_value;
    logic         cap_flag, ovr_flag, cmp_out, match_pulse, sig_cond;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tcc_channel #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .upd_evt(upd_evt),
        .prot_lvl(prot_lvl), .sig_in(sig_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_rd(ctrl_rd), .ch_value(ch_value),
        .cap_flag(cap_flag), .ovr_flag(ovr_flag), .cmp_out(cmp_out),
        .match_pulse(match_pulse), .sig_cond(sig_cond)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [W-1:0] exp_val;
        bit           exp_cap, exp_ovr;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(ctrl_rd == 4'h0, "R1 ctrl", ctrl_rd, 0);
        chk(ch_value == '0, "R1 value", ch_value, 0);
        chk({cap_flag, ovr_flag, cmp_out, match_pulse} == 4'b0, "R1 outputs",
            {cap_flag, ovr_flag, cmp_out, match_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5 R6: exhaustive compare sweep
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 3; t++) begin
                logic [W-1:0] thr;
                thr = (t == 0) ? 8'h00 : (t == 1) ? 8'h80 : 8'hFF;
                wr(2'd0, W'(p << 2));
                wr(2'd1, thr);
                chk(ch_value == thr, "R6 unbuffered write", ch_value, thr);
                chk(ctrl_rd == 4'(p << 2), "R2 ctrl readback", ctrl_rd, p << 2);
                for (int c = 0; c < 256; c++) begin
                    bit eo;
                    @(negedge clk) cnt_val = W'(c);
                    @(negedge clk);
                    eo = (W'(c) >= thr) ^ p[0];
                    chk(cmp_out == eo, "R3 compare output", cmp_out, eo);
                    chk(match_pulse == (W'(c) == thr), "R5 match", match_pulse, W'(c) == thr);
                end
            end
        end

        // R4: reserved codes keep the inverted sense
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h80);
        for (int r = 2; r < 4; r++) begin
            wr(2'd0, W'(r << 2));
            chk(ctrl_rd == 4'(r << 2), "R4 code stored", ctrl_rd, r << 2);
            @(negedge clk) cnt_val = 8'h90;
            repeat (3) @(negedge clk);
            chk(cmp_out == 1'b0, "R4 reserved above", cmp_out, 0);
            @(negedge clk) cnt_val = 8'h10;
            repeat (3) @(negedge clk);
            chk(cmp_out == 1'b1, "R4 reserved below", cmp_out, 1);
        end
        wr(2'd0, 8'h00);
        @(negedge clk) cnt_val = 8'h90;
        repeat (3) @(negedge clk);
        chk(cmp_out == 1'b1, "R4 back to high", cmp_out, 1);

        // R7: double-buffered threshold
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h40);
        chk(ch_value == 8'h80, "R7 held", ch_value, 8'h80);
        repeat (3) @(negedge clk);
        chk(ch_value == 8'h80, "R7 still held", ch_value, 8'h80);
        upd_evt = 1'b1;
        @(negedge clk) upd_evt = 1'b0;
        chk(ch_value == 8'h40, "R7 loaded on update", ch_value, 8'h40);

        // R13: polarity lock
        wr(2'd0, 8'h00);
        for (int l = 2; l < 4; l++) begin
            prot_lvl = 2'(l);
            wr(2'd0, 8'h04);
            chk(ctrl_rd == 4'h0, "R13 locked", ctrl_rd, 0);
        end
        prot_lvl = 2'b10;
        wr(2'd0, 8'h0F);
        chk(ctrl_rd == 4'h3, "R13 mode bits still written", ctrl_rd, 3);
        prot_lvl = 2'b01;
        wr(2'd0, 8'h04);
        chk(ctrl_rd == 4'h4, "R13 unlocked", ctrl_rd, 4);
        prot_lvl = 2'b00;

        // R8 R9 R10 R12: capture sweep over all codes
        exp_val = ch_value;
        for (int p = 0; p < 4; p++) begin
            wr(2'd0, W'((p << 2) | 1));
            wr(2'd2, 8'h03);
            exp_cap = 0; exp_ovr = 0;
            for (int k = 0; k < 4; k++) begin
                logic [W-1:0] c;
                bit lvl, hit, ec;
                lvl = ~sig_in;
                c = W'(p * 16 + k + 1);
                hit = (p == 0 && lvl) || (p == 1 && !lvl) || (p == 3);
                @(negedge clk);
                cnt_val = c; sig_in = lvl;
                repeat (4) @(negedge clk);
                if (hit) begin
                    exp_val = c;
                    if (exp_cap) exp_ovr = 1;
                    exp_cap = 1;
                end
                chk(ch_value == exp_val, "R8 R10 captured value", ch_value, exp_val);
                chk(cap_flag == exp_cap, "R12 capture flag", cap_flag, exp_cap);
                chk(ovr_flag == exp_ovr, "R12 overcapture flag", ovr_flag, exp_ovr);
                ec = (p == 1) ? !lvl : lvl;
                chk(sig_cond == ec, "R9 conditioned input", sig_cond, ec);
                chk(cmp_out == 1'b0, "R3 idle in capture", cmp_out, 0);
            end
        end
        wr(2'd2, 8'h01);
        chk(cap_flag == 1'b0 && ovr_flag == 1'b1, "R12 clear cap only",
            {cap_flag, ovr_flag}, 2'b01);
        wr(2'd2, 8'h02);
        chk(ovr_flag == 1'b0, "R12 clear ovr", ovr_flag, 0);

        // R11: value write ignored in capture mode
        wr(2'd1, 8'h99);
        chk(ch_value == exp_val, "R11 read-only", ch_value, exp_val);

        // R12: capture collides with a clear
        wr(2'd0, 8'h01);
        @(negedge clk);
        cnt_val = 8'hA5; sig_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        chk(cap_flag == 1'b1, "R12 capture beats clear", cap_flag, 1);
        chk(ch_value == 8'hA5, "R8 collision value", ch_value, 8'hA5);
        chk(ovr_flag == 1'b0, "R12 no overcapture", ovr_flag, 0);

        finish_run();
    end

endmodule